// File: doc/BRIEF.md
# Serial Transmitter with Line Break and Half-Duplex Direction Control

This block serializes bytes onto an asynchronous serial line using a frame of one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. A separate rate generator supplies `bit_tick`, a single-cycle strobe once per bit time. Bytes enter through a valid/ready handshake. Every bit boundary on the line falls on a tick, and the line rests high when idle.

Two line-control features sit on top of the serializer. The first is a break request register. Any non-zero value drives the line low for as long as the value stays non-zero. A character that has already been accepted is sent in full before the break begins. The second is the direction output for an external half-duplex transceiver. The block raises this output before the start bit. After the last stop bit it keeps the output high for a programmable number of bit times, then returns the transceiver to receive. When half-duplex operation is off, the output stays high permanently.

Top module: `uart_tx_hd`

## Requirements
- R1: After reset, `tx_o` is 1 and `in_ready` is 1 while `brk_ctrl` is zero. With `hd_en` at 1, `xcvr_en_o` is 0.
- R2: An accepted byte appears on `tx_o` as a 0 start bit, then the eight data bits with bit 0 first, then a 1 stop bit. Each bit lasts exactly one tick period and starts on a tick.
- R3: A byte is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the cycle after that edge until the stop bit of that byte has ended.
- R4: When `brk_ctrl` becomes non-zero while the line is idle, `tx_o` goes to 0 in the next cycle and stays 0 while `brk_ctrl` is non-zero. When `brk_ctrl` returns to zero, `tx_o` is 1 again in the next cycle.
- R5: If `brk_ctrl` becomes non-zero while a byte is being sent, that byte is sent complete, stop bit included, before `tx_o` is held at 0.
- R6: While `brk_ctrl` is non-zero, `in_ready` is 0. A byte offered during a break is not taken and is never sent.
- R7: With `hd_en` at 1, `xcvr_en_o` is 1 from the cycle after a byte is accepted, which is before its start bit begins. With a non-zero `turn_dly`, it stays 1 between bytes sent back to back.
- R8: With `hd_en` at 1, `xcvr_en_o` falls on the `turn_dly`-th tick after the end of the last stop bit. `turn_dly` is a 4-bit count of bit times. A value of 0 releases `xcvr_en_o` on the same edge that the stop bit ends.
- R9: A byte accepted while the turnaround count is running cancels the count, and `xcvr_en_o` stays 1. After that byte's stop bit, a fresh full count starts.
- R10: With `hd_en` at 0, `xcvr_en_o` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Block can take a byte this cycle |
| brk_ctrl | input | 8 | Break request register; non-zero requests a break |
| hd_en | input | 1 | Half-duplex direction control enable |
| turn_dly | input | 4 | Turnaround delay in bit times |
| tx_o | output | 1 | Serial line output |
| xcvr_en_o | output | 1 | Transceiver drive enable (1 = transmit) |

## Verification
The hardest situation to reach from the ports is a second byte arriving inside the turnaround window. The stimulus waits for `in_ready` to rise at the end of the first stop bit, lets a few cycles pass inside a six-bit-time window, and then offers the next byte. It watches `xcvr_en_o` every cycle until that byte finishes, then times the fresh release. A break raised mid-character is reached by detecting the start bit on the line and writing `brk_ctrl` immediately afterwards. The bench decodes the rest of the frame and checks that the line goes low only after the stop bit.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_ARM,
        TS_START,
        TS_DATA,
        TS_STOP,
        TS_BREAK
    } tx_state_e;

    typedef enum logic [1:0] {
        DS_RX,
        DS_TX,
        DS_TURN
    } dir_state_e;

endpackage

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              brk_req,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              tx_o,
    output logic              busy_nx,
    output logic              line_busy,
    output logic              brk_active
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        tx_state_e         st;
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              tx;
    } shift_t;

    shift_t r_d, r_q;
    logic   accept;

    assign in_ready = (r_q.st == TS_IDLE) && !brk_req;
    assign accept   = in_valid && in_ready;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            TS_IDLE: begin
                r_d.tx = 1'b1;
                if (brk_req) begin
                    // break only starts from an idle line
                    r_d.st = TS_BREAK;
                    r_d.tx = 1'b0;
                end else if (accept) begin
                    r_d.st = TS_ARM;
                    r_d.sh = in_data;
                end
            end
            TS_ARM: begin
                // wait for a bit boundary so the start bit is full length
                if (bit_tick) begin
                    r_d.st = TS_START;
                    r_d.tx = 1'b0;
                end
            end
            TS_START: begin
                if (bit_tick) begin
                    r_d.st  = TS_DATA;
                    r_d.tx  = r_q.sh[0];
                    r_d.sh  = r_q.sh >> 1;
                    r_d.cnt = '0;
                end
            end
            TS_DATA: begin
                if (bit_tick) begin
                    if (r_q.cnt == LAST_BIT) begin
                        r_d.st = TS_STOP;
                        r_d.tx = 1'b1;
                    end else begin
                        r_d.tx  = r_q.sh[0];
                        r_d.sh  = r_q.sh >> 1;
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
            end
            TS_STOP: begin
                if (bit_tick) begin
                    if (brk_req) begin
                        r_d.st = TS_BREAK;
                        r_d.tx = 1'b0;
                    end else begin
                        r_d.st = TS_IDLE;
                        r_d.tx = 1'b1;
                    end
                end
            end
            TS_BREAK: begin
                r_d.tx = 1'b0;
                if (!brk_req) begin
                    r_d.st = TS_IDLE;
                    r_d.tx = 1'b1;
                end
            end
            default: begin
                r_d.st = TS_IDLE;
                r_d.tx = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= TS_IDLE;
            r_q.sh  <= '0;
            r_q.cnt <= '0;
            r_q.tx  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_o       = r_q.tx;
    assign busy_nx    = (r_d.st != TS_IDLE);
    assign line_busy  = (r_q.st != TS_IDLE);
    assign brk_active = (r_q.st == TS_BREAK);

endmodule

// File: rtl/uart_tx_dir_ctrl.sv
module uart_tx_dir_ctrl
    import uart_tx_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             hd_en,
    input  logic [DLY_W-1:0] turn_dly,
    input  logic             busy_nx,
    output logic             xcvr_en_o
);

    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    typedef struct packed {
        dir_state_e       st;
        logic [DLY_W-1:0] cnt;
    } dir_t;

    dir_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            DS_RX: begin
                if (busy_nx) r_d.st = DS_TX;
            end
            DS_TX: begin
                if (!busy_nx) begin
                    if (turn_dly == '0) begin
                        r_d.st = DS_RX;
                    end else begin
                        r_d.st  = DS_TURN;
                        r_d.cnt = turn_dly;
                    end
                end
            end
            DS_TURN: begin
                if (busy_nx) begin
                    // new traffic cancels the pending turnaround
                    r_d.st = DS_TX;
                end else if (bit_tick) begin
                    if (r_q.cnt == ONE) r_d.st = DS_RX;
                    else                r_d.cnt = r_q.cnt - ONE;
                end
            end
            default: r_d.st = DS_RX;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= DS_RX;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign xcvr_en_o = !hd_en || (r_q.st != DS_RX);

endmodule

// File: rtl/uart_tx_hd.sv
module uart_tx_hd
#(
    parameter int DATA_W = 8,
    parameter int BRK_W  = 8,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BRK_W-1:0]  brk_ctrl,
    input  logic              hd_en,
    input  logic [DLY_W-1:0]  turn_dly,
    output logic              tx_o,
    output logic              xcvr_en_o
);

    logic brk_req;
    logic busy_nx;
    logic line_busy;
    logic brk_active;

    assign brk_req = |brk_ctrl;

    uart_tx_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .brk_req    (brk_req),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .tx_o       (tx_o),
        .busy_nx    (busy_nx),
        .line_busy  (line_busy),
        .brk_active (brk_active)
    );

    uart_tx_dir_ctrl #(
        .DLY_W (DLY_W)
    ) u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .hd_en     (hd_en),
        .turn_dly  (turn_dly),
        .busy_nx   (busy_nx),
        .xcvr_en_o (xcvr_en_o)
    );

endmodule

// File: rtl/uart_tx_hd_chk.sv
module uart_tx_hd_chk #(
    parameter int BRK_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [BRK_W-1:0] brk_ctrl,
    input logic             hd_en,
    input logic             tx_o,
    input logic             xcvr_en_o,
    input logic             line_busy,
    input logic             brk_active
);

    assert_ready_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_break_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        brk_active |-> !tx_o);

    assert_break_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_active && (brk_ctrl != '0)) |=> brk_active);

    assert_no_ready_in_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_active |-> !in_ready);

    assert_busy_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_busy |-> xcvr_en_o);

    assert_release_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(xcvr_en_o) && $past(hd_en)) |-> !line_busy);

endmodule

bind uart_tx_hd uart_tx_hd_chk #(.BRK_W(BRK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .brk_ctrl   (brk_ctrl),
    .hd_en      (hd_en),
    .tx_o       (tx_o),
    .xcvr_en_o  (xcvr_en_o),
    .line_busy  (line_busy),
    .brk_active (brk_active)
);

// File: tb/uart_tx_hd_tb.sv
`timescale 1ns/1ps
module uart_tx_hd_tb;

    localparam int TPB = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] brk_ctrl = '0;
    logic       hd_en = 1'b1;
    logic [3:0] turn_dly = '0;
    logic       tx_o;
    logic       xcvr_en_o;

    int total = 0;
    int bad = 0;
    int tick_cnt = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= 0;
            bit_tick <= 1'b0;
        end else begin
            tick_cnt <= (tick_cnt == TPB - 1) ? 0 : tick_cnt + 1;
            bit_tick <= (tick_cnt == TPB - 1);
        end
    end

    uart_tx_hd u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .brk_ctrl  (brk_ctrl),
        .hd_en     (hd_en),
        .turn_dly  (turn_dly),
        .tx_o      (tx_o),
        .xcvr_en_o (xcvr_en_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_data  = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_start();
        while (tx_o !== 1'b0) @(negedge clk);
    endtask

    task automatic rx_after_start(output logic [7:0] b, output logic start_ok, output logic stop_bit);
        repeat (TPB / 2) @(negedge clk);
        start_ok = (tx_o == 1'b0);
        for (int i = 0; i < 8; i++) begin
            repeat (TPB) @(negedge clk);
            b[i] = tx_o;
        end
        repeat (TPB) @(negedge clk);
        stop_bit = tx_o;
    endtask

    task automatic wait_ready_watch(output int drops);
        drops = 0;
        while (!in_ready) begin
            @(negedge clk);
            if (!xcvr_en_o) drops++;
        end
    endtask

    task automatic measure_release(output int n);
        n = 0;
        while (xcvr_en_o && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(tx_o == 1'b1, "R1 tx idle", int'(tx_o), 1);
        chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
        chk(xcvr_en_o == 1'b0, "R1 xcvr off", int'(xcvr_en_o), 0);
    endtask

    task automatic t_frame(input logic [7:0] b);
        logic [7:0] got;
        logic s_ok, stp;
        send(b);
        chk(in_ready == 1'b0, "R3 ready low after accept", int'(in_ready), 0);
        wait_start();
        rx_after_start(got, s_ok, stp);
        chk(s_ok == 1'b1, "R2 start bit", int'(s_ok), 1);
        chk(got == b, "R2 data bits", int'(got), int'(b));
        chk(stp == 1'b1, "R2 stop bit", int'(stp), 1);
        chk(in_ready == 1'b0, "R3 ready low in stop bit", int'(in_ready), 0);
        while (!in_ready) @(negedge clk);
    endtask

    task automatic t_break_idle();
        int lows = 0;
        int rdy = 0;
        @(negedge clk);
        brk_ctrl = 8'h01;
        in_data  = 8'h81;
        in_valid = 1'b1;
        @(negedge clk);
        chk(tx_o == 1'b0, "R4 tx low next cycle", int'(tx_o), 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tx_o == 1'b0) lows++;
            if (in_ready) rdy++;
        end
        chk(lows == 40, "R4 break held", lows, 40);
        chk(rdy == 0, "R6 ready low in break", rdy, 0);
        in_valid = 1'b0;
        brk_ctrl = 8'h00;
        @(negedge clk);
        chk(tx_o == 1'b1, "R4 tx high after clear", int'(tx_o), 1);
        chk(in_ready == 1'b1, "R4 ready after clear", int'(in_ready), 1);
        lows = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tx_o == 1'b0) lows++;
        end
        chk(lows == 0, "R6 offered byte not sent", lows, 0);
    endtask

    task automatic t_break_mid();
        logic [7:0] got;
        logic s_ok, stp;
        send(8'h55);
        wait_start();
        brk_ctrl = 8'h80;
        rx_after_start(got, s_ok, stp);
        chk(got == 8'h55, "R5 byte completes", int'(got), 8'h55);
        chk(stp == 1'b1, "R5 stop bit before break", int'(stp), 1);
        repeat (TPB) @(negedge clk);
        chk(tx_o == 1'b0, "R5 break after char", int'(tx_o), 0);
        chk(in_ready == 1'b0, "R6 ready low", int'(in_ready), 0);
        brk_ctrl = 8'h00;
        @(negedge clk);
        chk(tx_o == 1'b1, "R4 release", int'(tx_o), 1);
    endtask

    task automatic t_lead_b2b();
        int d;
        turn_dly = 4'd2;
        @(negedge clk);
        chk(xcvr_en_o == 1'b0, "R7 idle receive", int'(xcvr_en_o), 0);
        send(8'hC3);
        chk(xcvr_en_o == 1'b1 && tx_o == 1'b1, "R7 enable before start", int'(xcvr_en_o), 1);
        wait_ready_watch(d);
        send(8'h3C);
        chk(xcvr_en_o == 1'b1, "R7 enable held b2b", int'(xcvr_en_o), 1);
        wait_ready_watch(d);
        chk(d == 0, "R7 no drop during b2b", d, 0);
        measure_release(d);
    endtask

    task automatic t_turn(input logic [3:0] dly);
        int n, d;
        turn_dly = dly;
        send(8'hA5);
        wait_ready_watch(d);
        measure_release(n);
        chk(n == int'(dly) * TPB, "R8 turnaround cycles", n, int'(dly) * TPB);
    endtask

    task automatic t_cancel();
        int n, d;
        int drops = 0;
        turn_dly = 4'd6;
        send(8'h0F);
        wait_ready_watch(d);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!xcvr_en_o) drops++;
        end
        send(8'hF0);
        wait_ready_watch(d);
        drops += d;
        chk(drops == 0, "R9 count cancelled", drops, 0);
        measure_release(n);
        chk(n == 6 * TPB, "R9 fresh count", n, 6 * TPB);
    endtask

    task automatic t_hd_off();
        int d;
        int drops = 0;
        hd_en = 1'b0;
        turn_dly = 4'd0;
        @(negedge clk);
        chk(xcvr_en_o == 1'b1, "R10 enable when off", int'(xcvr_en_o), 1);
        send(8'h99);
        wait_ready_watch(d);
        drops += d;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!xcvr_en_o) drops++;
        end
        chk(drops == 0, "R10 never released", drops, 0);
        hd_en = 1'b1;
        @(negedge clk);
        chk(xcvr_en_o == 1'b0, "R10 back to receive", int'(xcvr_en_o), 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_frame(8'hA5);
        t_frame(8'h00);
        t_frame(8'hFF);
        t_frame(8'h6B);
        t_break_idle();
        t_break_mid();
        t_lead_b2b();
        t_turn(4'd0);
        t_turn(4'd3);
        t_turn(4'd15);
        t_cancel();
        t_hd_off();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule